// File: doc/BRIEF.md
# Binary Row Run Extractor

This block reads a binary image out of a synchronous pixel RAM in raster order, one pixel per clock, and turns each horizontal stretch of foreground pixels into one run record. A record carries the first and last foreground column of the stretch and its row index. It also carries a label field and an equivalence field, and both are written as zero so that a later labelling pass can fill them in. Records go into a run-table RAM through a simple write port, at consecutive addresses in raster order.

A frame starts with a one-cycle start strobe. When the last record is in the table, the block raises a one-cycle done pulse and presents the total number of runs. Image width and height are parameters. The run table is sized for the densest possible pattern, an alternating pixel checkerboard. One instance handles one band of rows. A taller image can be split across several instances, and each writes its own table.

Top module: `run_extractor`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `pix_rd_o`, `rt_we_o` and `done_o` are low and `run_count_o` is zero until a start strobe arrives.
- R2: A start strobe seen while idle reads every pixel exactly once, at addresses 0 to W*H-1 in consecutive cycles, where the address of column c in row r is r*W+c. A start strobe seen while busy (including the cycle of the done pulse) is ignored.
- R3: A run opens on a foreground pixel (data 1) when no run is open, and the column of that pixel becomes the record's start column.
- R4: An open run closes at the first background pixel (data 0). Its end column is the column just before that pixel, so start is never above end.
- R5: An open run always closes at column W-1 with end column W-1. A run never continues into the next row: all-foreground rows give one record per row.
- R6: A foreground pixel in column W-1 with no run open produces a single-pixel record with start and end both W-1.
- R7: Each record is one packed word, from MSB to LSB: label (LBL_W bits, zero), equivalence (LBL_W bits, zero), start column (COL_W), end column (COL_W), row (ROW_W). Records are written with `rt_we_o` at table addresses 0, 1, 2, … in raster order of their runs.
- R8: `done_o` is high for exactly one cycle, the cycle after the final record write. In that cycle `run_count_o` equals the number of records written, and it holds that value until the next frame starts. Counting from the clock edge that samples the start strobe, done appears after W*H+2 further edges.
- R9: A checkerboard image yields H*ceil(W/2) records, the full table depth, all stored.
- R10: An all-background image writes no record and still finishes with a done pulse and a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle frame start strobe |
| busy_o | output | 1 | High from an accepted start until the cycle after done |
| pix_rd_o | output | 1 | Pixel RAM read enable |
| pix_addr_o | output | PIX_AW | Pixel RAM read address (r*W+c) |
| pix_data_i | input | 1 | Pixel RAM read data, one cycle after the read |
| rt_we_o | output | 1 | Run-table write enable |
| rt_addr_o | output | RT_AW | Run-table write address |
| rt_wdata_o | output | REC_W | Packed run record |
| done_o | output | 1 | One-cycle frame-complete pulse |
| run_count_o | output | CNT_W | Total runs of the last frame |

## Verification
The hardest case to reach is a run that closes at the row edge in the same cycle as the block's internal row and column counters wrap. The single-pixel run in the last column, opened and closed in one cycle, is just as hard. At the ports both only show up if the image puts foreground in column W-1 with particular neighbours. The stimulus table therefore includes a last-column-only image, a checkerboard whose odd rows end in an isolated foreground pixel, and an all-foreground image where one row's run ends exactly as the next row's begins. A second start strobe is also fired in the middle of a scan, and the bench confirms that the read sequence and the records are unchanged.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,
    SCAN_RUN   = 2'd1,
    SCAN_DRAIN = 2'd2
  } scan_state_e;

  // Depth of a run table able to hold the densest pattern.
  function automatic int run_depth(input int w, input int h);
    return h * ((w + 1) / 2);
  endfunction
endpackage

// File: rtl/rle_pix_scanner.sv
module rle_pix_scanner
  import rle_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic                              done_i,
  output logic                              busy_o,
  output logic                              go_o,
  output logic                              pix_rd_o,
  output logic [$clog2(IMG_W*IMG_H)-1:0]    pix_addr_o,
  output logic                              vld_o,
  output logic [$clog2(IMG_W)-1:0]          col_o,
  output logic [$clog2(IMG_H)-1:0]          row_o,
  output logic                              last_o
);
  localparam int AW    = $clog2(IMG_W*IMG_H);
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);
  localparam logic [AW-1:0]    LAST_A = AW'(IMG_W*IMG_H-1);
  localparam logic [COL_W-1:0] LAST_C = COL_W'(IMG_W-1);
  localparam logic [AW-1:0]    ONE_A  = AW'(1);
  localparam logic [COL_W-1:0] ONE_C  = COL_W'(1);
  localparam logic [ROW_W-1:0] ONE_R  = ROW_W'(1);

  scan_state_e       state_q, state_n;
  logic [COL_W-1:0]  col_q, col_n;
  logic [ROW_W-1:0]  row_q, row_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic              ctr_en;
  logic              reading;

  assign reading = (state_q == SCAN_RUN);
  assign go_o    = (state_q == SCAN_IDLE) && start_i;
  assign ctr_en  = reading || go_o;

  always_comb begin
    state_n = state_q;
    col_n   = col_q;
    row_n   = row_q;
    addr_n  = addr_q;
    case (state_q)
      SCAN_IDLE: begin
        if (start_i) begin
          state_n = SCAN_RUN;
          col_n   = '0;
          row_n   = '0;
          addr_n  = '0;
        end
      end
      SCAN_RUN: begin
        addr_n = addr_q + ONE_A;
        if (col_q == LAST_C) begin
          col_n = '0;
          row_n = row_q + ONE_R;
        end else begin
          col_n = col_q + ONE_C;
        end
        if (addr_q == LAST_A) state_n = SCAN_DRAIN;
      end
      SCAN_DRAIN: begin
        if (done_i) state_n = SCAN_IDLE;
      end
      default: state_n = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      addr_q <= '0;
    end else if (ctr_en) begin
      col_q  <= col_n;
      row_q  <= row_n;
      addr_q <= addr_n;
    end
  end

  // Position tags delayed by the RAM read latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      col_o  <= '0;
      row_o  <= '0;
      last_o <= 1'b0;
    end else begin
      vld_o  <= reading;
      last_o <= reading && (addr_q == LAST_A);
      if (reading) begin
        col_o <= col_q;
        row_o <= row_q;
      end
    end
  end

  assign pix_rd_o   = reading;
  assign pix_addr_o = addr_q;
  assign busy_o     = (state_q != SCAN_IDLE);
endmodule

// File: rtl/rle_run_tracker.sv
module rle_run_tracker #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vld_i,
  input  logic                      pix_i,
  input  logic [$clog2(IMG_W)-1:0]  col_i,
  input  logic [$clog2(IMG_H)-1:0]  row_i,
  input  logic                      last_i,
  output logic                      emit_o,
  output logic [$clog2(IMG_W)-1:0]  start_o,
  output logic [$clog2(IMG_W)-1:0]  end_o,
  output logic [$clog2(IMG_H)-1:0]  row_o,
  output logic                      last_o
);
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);
  localparam logic [COL_W-1:0] LAST_C = COL_W'(IMG_W-1);
  localparam logic [COL_W-1:0] ONE_C  = COL_W'(1);

  logic             open_q, open_n;
  logic [COL_W-1:0] head_q, head_n;
  logic             close_bg, close_edge, emit_n;
  logic [COL_W-1:0] rs_n, re_n;

  always_comb begin
    close_bg   = vld_i && open_q && !pix_i;
    close_edge = vld_i && pix_i && (col_i == LAST_C);
    emit_n     = close_bg || close_edge;
    rs_n       = open_q ? head_q : col_i;
    re_n       = close_bg ? (col_i - ONE_C) : col_i;
    open_n     = open_q;
    head_n     = head_q;
    if (vld_i) begin
      if (emit_n) begin
        open_n = 1'b0;
      end else if (pix_i && !open_q) begin
        open_n = 1'b1;
        head_n = col_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      head_q <= '0;
    end else if (vld_i) begin
      open_q <= open_n;
      head_q <= head_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit_o  <= 1'b0;
      last_o  <= 1'b0;
      start_o <= '0;
      end_o   <= '0;
      row_o   <= '0;
    end else begin
      emit_o <= emit_n;
      last_o <= vld_i && last_i;
      if (emit_n) begin
        start_o <= rs_n;
        end_o   <= re_n;
        row_o   <= row_i;
      end
    end
  end
endmodule

// File: rtl/rle_run_sink.sv
module rle_run_sink #(
  parameter int LBL_W = 8,
  parameter int COL_W = 6,
  parameter int ROW_W = 6,
  parameter int RT_AW = 8,
  parameter int CNT_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go_i,
  input  logic                          emit_i,
  input  logic [COL_W-1:0]              start_i,
  input  logic [COL_W-1:0]              end_i,
  input  logic [ROW_W-1:0]              row_i,
  input  logic                          last_i,
  output logic                          rt_we_o,
  output logic [RT_AW-1:0]              rt_addr_o,
  output logic [2*LBL_W+2*COL_W+ROW_W-1:0] rt_wdata_o,
  output logic                          done_o,
  output logic [CNT_W-1:0]              count_o
);
  localparam logic [CNT_W-1:0] ONE_N = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  assign cnt_en = go_i || emit_i;

  always_comb begin
    if (go_i) cnt_n = '0;
    else      cnt_n = cnt_q + ONE_N;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
    end else begin
      done_o <= last_i;
    end
  end

  assign rt_we_o    = emit_i;
  assign rt_addr_o  = cnt_q[RT_AW-1:0];
  assign rt_wdata_o = {{LBL_W{1'b0}}, {LBL_W{1'b0}}, start_i, end_i, row_i};
  assign count_o    = cnt_q;
endmodule

// File: rtl/run_extractor.sv
module run_extractor
  import rle_pkg::*;
#(
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 48,
  localparam int DEPTH  = run_depth(IMG_W, IMG_H),
  localparam int PIX_AW = $clog2(IMG_W*IMG_H),
  localparam int COL_W  = $clog2(IMG_W),
  localparam int ROW_W  = $clog2(IMG_H),
  localparam int CNT_W  = $clog2(DEPTH+1),
  localparam int LBL_W  = CNT_W,
  localparam int RT_AW  = $clog2(DEPTH),
  localparam int REC_W  = 2*LBL_W + 2*COL_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              pix_rd_o,
  output logic [PIX_AW-1:0] pix_addr_o,
  input  logic              pix_data_i,
  output logic              rt_we_o,
  output logic [RT_AW-1:0]  rt_addr_o,
  output logic [REC_W-1:0]  rt_wdata_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  run_count_o
);
  logic             go;
  logic             vld_d, last_d;
  logic [COL_W-1:0] col_d;
  logic [ROW_W-1:0] row_d;
  logic             emit_q, last_q;
  logic [COL_W-1:0] rs_q, re_q;
  logic [ROW_W-1:0] rr_q;

  rle_pix_scanner #(.IMG_W(IMG_W), .IMG_H(IMG_H)) scan_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_i     (done_o),
    .busy_o     (busy_o),
    .go_o       (go),
    .pix_rd_o   (pix_rd_o),
    .pix_addr_o (pix_addr_o),
    .vld_o      (vld_d),
    .col_o      (col_d),
    .row_o      (row_d),
    .last_o     (last_d)
  );

  rle_run_tracker #(.IMG_W(IMG_W), .IMG_H(IMG_H)) trk_u (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (vld_d),
    .pix_i   (pix_data_i),
    .col_i   (col_d),
    .row_i   (row_d),
    .last_i  (last_d),
    .emit_o  (emit_q),
    .start_o (rs_q),
    .end_o   (re_q),
    .row_o   (rr_q),
    .last_o  (last_q)
  );

  rle_run_sink #(
    .LBL_W(LBL_W), .COL_W(COL_W), .ROW_W(ROW_W), .RT_AW(RT_AW), .CNT_W(CNT_W)
  ) sink_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go),
    .emit_i     (emit_q),
    .start_i    (rs_q),
    .end_i      (re_q),
    .row_i      (rr_q),
    .last_i     (last_q),
    .rt_we_o    (rt_we_o),
    .rt_addr_o  (rt_addr_o),
    .rt_wdata_o (rt_wdata_o),
    .done_o     (done_o),
    .count_o    (run_count_o)
  );
endmodule

// File: rtl/run_extractor_chk.sv
module run_extractor_chk
  import rle_pkg::*;
#(
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 48,
  localparam int DEPTH  = run_depth(IMG_W, IMG_H),
  localparam int PIX_AW = $clog2(IMG_W*IMG_H),
  localparam int COL_W  = $clog2(IMG_W),
  localparam int ROW_W  = $clog2(IMG_H),
  localparam int CNT_W  = $clog2(DEPTH+1),
  localparam int LBL_W  = CNT_W,
  localparam int RT_AW  = $clog2(DEPTH),
  localparam int REC_W  = 2*LBL_W + 2*COL_W + ROW_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              pix_rd_o,
  input logic [PIX_AW-1:0] pix_addr_o,
  input logic              rt_we_o,
  input logic [RT_AW-1:0]  rt_addr_o,
  input logic [REC_W-1:0]  rt_wdata_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  run_count_o
);
  localparam logic [PIX_AW-1:0] ONE_A = PIX_AW'(1);
  localparam logic [RT_AW-1:0]  ONE_T = RT_AW'(1);

  logic [COL_W-1:0] f_start, f_end;
  logic [ROW_W-1:0] f_row;
  assign f_row   = rt_wdata_o[ROW_W-1:0];
  assign f_end   = rt_wdata_o[ROW_W +: COL_W];
  assign f_start = rt_wdata_o[ROW_W+COL_W +: COL_W];

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!pix_rd_o && !rt_we_o));

  // R2
  rd_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rd_o && $past(pix_rd_o)) |-> (pix_addr_o == $past(pix_addr_o) + ONE_A));

  // R4
  rec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we_o |-> (f_start <= f_end));

  // R5
  rec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we_o |-> ((int'(f_end) < IMG_W) && (int'(f_row) < IMG_H)));

  // R7
  wr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_we_o && $past(rt_we_o)) |-> (rt_addr_o == $past(rt_addr_o) + ONE_T));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!rt_we_o && !pix_rd_o));

  // R9
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_count_o) <= DEPTH);
endmodule

bind run_extractor run_extractor_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) chk_i (.*);

// File: tb/run_extractor_tb_top.sv
`timescale 1ns/1ps
module run_extractor_tb_top;
  localparam int W      = 8;
  localparam int H      = 4;
  localparam int NPIX   = W*H;
  localparam int DEPTH  = H*((W+1)/2);
  localparam int PIX_AW = $clog2(NPIX);
  localparam int COL_W  = $clog2(W);
  localparam int ROW_W  = $clog2(H);
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int LBL_W  = CNT_W;
  localparam int RT_AW  = $clog2(DEPTH);
  localparam int REC_W  = 2*LBL_W + 2*COL_W + ROW_W;
  localparam int NVEC   = 6;

  // Bit r*W+c is the pixel at column c of row r.
  localparam logic [NPIX-1:0] IMGS [NVEC] = '{
    32'h0000_0000,  // all background          (R10)
    32'hFFFF_FFFF,  // all foreground          (R5)
    32'hAA55_AA55,  // checkerboard            (R9, R6)
    32'h8080_8080,  // last column only        (R6)
    32'h007E_6666,  // U shape                 (R3, R4)
    32'hF00F_0183   // mixed                   (R3, R4, R5)
  };
  localparam int EXPC [NVEC] = '{0, 4, 16, 4, 5, 5};

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic busy_o, pix_rd_o, rt_we_o, done_o;
  logic [PIX_AW-1:0] pix_addr_o;
  logic              pix_q;
  logic [RT_AW-1:0]  rt_addr_o;
  logic [REC_W-1:0]  rt_wdata_o;
  logic [CNT_W-1:0]  run_count_o;
  logic [NPIX-1:0]   cur_img;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [REC_W-1:0] exp_tab [DEPTH];
  logic [REC_W-1:0] got_tab [DEPTH];
  int exp_n;

  always #2 clk = ~clk;

  // Pixel RAM: registered read, one cycle latency.
  always @(posedge clk) if (pix_rd_o) pix_q <= cur_img[pix_addr_o];

  run_extractor #(.IMG_W(W), .IMG_H(H)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .pix_rd_o    (pix_rd_o),
    .pix_addr_o  (pix_addr_o),
    .pix_data_i  (pix_q),
    .rt_we_o     (rt_we_o),
    .rt_addr_o   (rt_addr_o),
    .rt_wdata_o  (rt_wdata_o),
    .done_o      (done_o),
    .run_count_o (run_count_o)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic build_expected(input logic [NPIX-1:0] img);
    exp_n = 0;
    for (int r = 0; r < H; r++) begin
      bit open = 0;
      int s = 0;
      for (int c = 0; c < W; c++) begin
        bit p = img[r*W+c];
        if (p && !open) begin open = 1; s = c; end
        if (open && !p) begin
          exp_tab[exp_n] = {LBL_W'(0), LBL_W'(0), COL_W'(s), COL_W'(c-1), ROW_W'(r)};
          exp_n++; open = 0;
        end else if (open && c == W-1) begin
          exp_tab[exp_n] = {LBL_W'(0), LBL_W'(0), COL_W'(s), COL_W'(W-1), ROW_W'(r)};
          exp_n++; open = 0;
        end
      end
    end
  endtask

  task automatic run_frame(input logic [NPIX-1:0] img, input int expc,
                           input string tag, input bit extra_start);
    int cyc = 0, rd_n = 0, rd_bad = 0, wr_n = 0, wr_bad = 0, mism = -1;
    cur_img = img;
    build_expected(img);
    check(exp_n == expc, {tag, " table count vs model"}, exp_n, expc);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    forever begin
      if (pix_rd_o) begin
        if (int'(pix_addr_o) != rd_n) rd_bad++;
        rd_n++;
      end
      if (rt_we_o) begin
        if (int'(rt_addr_o) != wr_n) wr_bad++;
        if (wr_n < DEPTH) got_tab[wr_n] = rt_wdata_o;
        wr_n++;
      end
      if (done_o || cyc > 4*NPIX) break;
      @(negedge clk);
      cyc++;
      if (extra_start) start_i = (cyc == 5);
    end
    start_i = 1'b0;
    check(done_o && cyc == NPIX+2, {tag, " R8 done latency"}, cyc, NPIX+2);
    check(int'(run_count_o) == exp_n, {tag, " R8 run count"}, run_count_o, exp_n);
    check(rd_n == NPIX && rd_bad == 0, {tag, " R2 read sequence"}, rd_n, NPIX);
    check(wr_n == exp_n && wr_bad == 0, {tag, " R7 write addresses"}, wr_n, exp_n);
    for (int i = 0; i < exp_n && i < DEPTH; i++)
      if (mism < 0 && got_tab[i] !== exp_tab[i]) mism = i;
    if (mism >= 0)
      check(0, {tag, " R3 R4 R5 R6 R7 record"}, got_tab[mism], exp_tab[mism]);
    else
      check(1, "", 0, 0);
    @(negedge clk);
    check(!done_o && int'(run_count_o) == exp_n, {tag, " R8 count hold"}, run_count_o, exp_n);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    cur_img = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busy_o && !pix_rd_o && !rt_we_o && !done_o, "R1 outputs in reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release
    check(!busy_o && !pix_rd_o && !rt_we_o && !done_o && run_count_o == '0,
          "R1 idle after reset", run_count_o, 0);

    for (int v = 0; v < NVEC; v++)
      run_frame(IMGS[v], EXPC[v], $sformatf("vec%0d", v), 1'b0);

    // R2: second start in the middle of a scan has no effect
    run_frame(32'hF00F_0183, 5, "R2 restart ignored", 1'b1);
    // R10 again straight after a dense frame: count must clear
    run_frame(32'h0000_0000, 0, "R10 clear after dense", 1'b0);
    // R6 back to back on the checkerboard, R9 full table
    run_frame(32'hAA55_AA55, DEPTH, "R9 full table", 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule